// File: doc/BRIEF.md
# Keypad Autorepeat Code Generator

This block sits between a keypad debouncer and the key event queue. While at least one key is held, it counts debounce-cycle ticks from the most recent recorded key event. Once a programmed delay has passed, it pushes one fixed repeat code into the queue. After that it pushes the same code again each time a programmed interval elapses. Any new key event, press or release, cancels the running sequence. If a key is still down after that event, the sequence starts over from the delay.

The repeat marker is one shared code. The number of the held key is never pushed again. Only one marker is pushed per interval, however many keys are down. An 8-bit configuration word sets the following:
- an enable bit;
- a 4-bit delay field, counted in units of 8 ticks;
- a 3-bit interval field, counted in units of 4 ticks.

The reset input is asynchronous and active low. Its release is synchronized inside the block, so the block starts working two clock edges after `rst_n` rises.

Top module: `kp_autorepeat`

## Requirements
- R1: After reset, `push_o` is 0 and `code_o` is 0x00.
- R2: When `cfg_i[7]` is 0, no marker is pushed, and the sequence state is cleared.
- R3: After a key event while `held_i` is 1, the first marker is pushed on the 8×(`cfg_i[3:0]`+1)-th tick. A tick is counted when `tick_i` is high at a clock edge, and `push_o` goes high for one cycle right after the edge that counted the last tick.
- R4: After a marker, further markers follow every 4×(`cfg_i[6:4]`+1) ticks. Each marker is a single-cycle pulse of `push_o`.
- R5: While `push_o` is 1, `code_o` is 0x7E. Otherwise `code_o` is 0x00.
- R6: A key event (`evt_i`=1), whether press or release, cancels the running sequence. If `held_i` is still 1, the delay count starts again from zero.
- R7: When `held_i` is 0, the block returns to idle with its count cleared. No marker is pushed until the next key event, even if `held_i` rises again.
- R8: When `evt_i` and `tick_i` are high in the same cycle, the event wins: that tick is not counted and no marker is pushed.
- R9: Setting the enable bit while a key is already held starts no sequence. Only a later key event starts one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle debounce-cycle tick |
| evt_i | input | 1 | A key press or release event was recorded |
| held_i | input | 1 | Level: at least one key is down |
| cfg_i | input | 8 | [7] enable, [6:4] interval field, [3:0] delay field |
| push_o | output | 1 | Single-cycle strobe: push the repeat marker |
| code_o | output | 8 | Repeat marker value, 0x7E while `push_o` is 1 |

## Verification
Directed runs use the smallest and largest delay fields with a tick on every other cycle. These runs confirm that the marker lands exactly on the last tick of the delay and of each interval, and not one tick early or late. Further directed cases check the following:
- an event arriving in the same cycle as a tick, which separates event priority from tick counting;
- the hold level dropping and coming back, which separates clearing the count from merely pausing it;
- enabling the block while a key is already held, which shows that only an event starts a sequence.

A long random phase varies the tick density, configuration, events and hold level. It compares every output cycle with a model built from the requirements, which catches errors in counter limits and in the restart ordering.

// File: rtl/kp_ar_pkg.sv
package kp_ar_pkg;

  typedef enum logic [1:0] {
    AR_IDLE   = 2'd0,
    AR_DELAY  = 2'd1,
    AR_REPEAT = 2'd2
  } ar_phase_e;

endpackage

// File: rtl/kp_ar_rst_sync.sv
module kp_ar_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/kp_ar_len_decode.sv
module kp_ar_len_decode #(
  parameter int DLY_W     = 4,
  parameter int RATE_W    = 3,
  parameter int DLY_UNIT  = 8,
  parameter int RATE_UNIT = 4,
  parameter int CNT_W     = 8,
  localparam int CFG_W    = DLY_W + RATE_W + 1
) (
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             sel_rate_i,
  output logic             en_o,
  output logic [CNT_W-1:0] limit_o
);

  logic [DLY_W-1:0]  dly_f;
  logic [RATE_W-1:0] rate_f;
  logic [CNT_W-1:0]  dly_len;
  logic [CNT_W-1:0]  rate_len;

  assign dly_f  = cfg_i[DLY_W-1:0];
  assign rate_f = cfg_i[DLY_W +: RATE_W];
  assign en_o   = cfg_i[CFG_W-1];

  always_comb begin
    dly_len  = CNT_W'((32'(dly_f) + 32'd1) * DLY_UNIT);
    rate_len = CNT_W'((32'(rate_f) + 32'd1) * RATE_UNIT);
    limit_o  = sel_rate_i ? rate_len : dly_len;
  end

endmodule

// File: rtl/kp_ar_tick_counter.sv
module kp_ar_tick_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign hit_o   = !clr_i && tick_i && (cnt_inc >= {1'b0, limit_i});
  assign cnt_en  = clr_i || tick_i;

  always_comb begin
    if (clr_i || hit_o) cnt_nxt = '0;
    else                cnt_nxt = cnt_inc[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/kp_ar_seq_ctrl.sv
module kp_ar_seq_ctrl
  import kp_ar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic held_i,
  input  logic evt_i,
  input  logic hit_i,
  output logic clr_o,
  output logic sel_rate_o,
  output logic push_o
);

  ar_phase_e phase_q, phase_nxt;
  logic      push_q, push_nxt;
  logic      active;

  assign active     = en_i && held_i;
  assign clr_o      = !active || evt_i || (phase_q == AR_IDLE);
  assign sel_rate_o = (phase_q == AR_REPEAT);

  always_comb begin
    phase_nxt = phase_q;
    push_nxt  = 1'b0;
    if (!active) begin
      phase_nxt = AR_IDLE;
    end else if (evt_i) begin
      phase_nxt = AR_DELAY;
    end else if (hit_i) begin
      phase_nxt = AR_REPEAT;
      push_nxt  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= AR_IDLE;
      push_q  <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      push_q  <= push_nxt;
    end
  end

  assign push_o = push_q;

endmodule

// File: rtl/kp_autorepeat.sv
module kp_autorepeat #(
  parameter int         DLY_W     = 4,
  parameter int         RATE_W    = 3,
  parameter int         DLY_UNIT  = 8,
  parameter int         RATE_UNIT = 4,
  parameter int         CODE_W    = 8,
  parameter logic [7:0] REP_CODE  = 8'h7E,
  localparam int CFG_W   = DLY_W + RATE_W + 1,
  localparam int DLY_MAX = DLY_UNIT * (1 << DLY_W),
  localparam int RAT_MAX = RATE_UNIT * (1 << RATE_W),
  localparam int LEN_MAX = (DLY_MAX > RAT_MAX) ? DLY_MAX : RAT_MAX,
  localparam int CNT_W   = $clog2(LEN_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              evt_i,
  input  logic              held_i,
  input  logic [CFG_W-1:0]  cfg_i,
  output logic              push_o,
  output logic [CODE_W-1:0] code_o
);

  logic             rst_sync_n;
  logic             en;
  logic             clr;
  logic             sel_rate;
  logic             hit;
  logic [CNT_W-1:0] limit;

  kp_ar_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  kp_ar_len_decode #(
    .DLY_W(DLY_W), .RATE_W(RATE_W), .DLY_UNIT(DLY_UNIT),
    .RATE_UNIT(RATE_UNIT), .CNT_W(CNT_W)
  ) u_dec (
    .cfg_i      (cfg_i),
    .sel_rate_i (sel_rate),
    .en_o       (en),
    .limit_o    (limit)
  );

  kp_ar_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (clr),
    .tick_i  (tick_i),
    .limit_i (limit),
    .hit_o   (hit)
  );

  kp_ar_seq_ctrl u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .en_i       (en),
    .held_i     (held_i),
    .evt_i      (evt_i),
    .hit_i      (hit),
    .clr_o      (clr),
    .sel_rate_o (sel_rate),
    .push_o     (push_o)
  );

  assign code_o = push_o ? CODE_W'(REP_CODE) : '0;

endmodule

// File: rtl/kp_autorepeat_chk.sv
module kp_autorepeat_chk #(
  parameter int CFG_W  = 8,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              evt_i,
  input logic              held_i,
  input logic [CFG_W-1:0]  cfg_i,
  input logic              push_o,
  input logic [CODE_W-1:0] code_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !push_o); // R1

  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i[CFG_W-1] |=> !push_o); // R2

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |=> !push_o); // R4

  AST_PUSH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !push_o); // R3

  AST_CODE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> (code_o == CODE_W'(8'h7E))); // R5

  AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !push_o |-> (code_o == '0)); // R5

  AST_EVENT_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_i |=> !push_o); // R6

  AST_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !held_i |=> !push_o); // R7

endmodule

bind kp_autorepeat kp_autorepeat_chk #(.CFG_W(CFG_W), .CODE_W(CODE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .tick_i (tick_i),
  .evt_i  (evt_i),
  .held_i (held_i),
  .cfg_i  (cfg_i),
  .push_o (push_o),
  .code_o (code_o)
);

// File: tb/kp_autorepeat_tb.sv
module kp_autorepeat_tb_top;

  logic       clk;
  logic       rst_n;
  logic       tick_i;
  logic       evt_i;
  logic       held_i;
  logic [7:0] cfg_i;
  logic       push_o;
  logic [7:0] code_o;

  int errors = 0;
  int checks = 0;

  // reference model state
  int m_phase = 0;
  int m_cnt   = 0;
  bit m_push  = 0;
  bit model_on = 0;

  kp_autorepeat dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .evt_i(evt_i),
    .held_i(held_i), .cfg_i(cfg_i), .push_o(push_o), .code_o(code_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int dly_len(input logic [7:0] c);
    return 8 * (int'(c[3:0]) + 1);
  endfunction

  function automatic int rate_len(input logic [7:0] c);
    return 4 * (int'(c[6:4]) + 1);
  endfunction

  task automatic model_step();
    m_push = 0;
    if (!cfg_i[7] || !held_i) begin
      m_phase = 0; m_cnt = 0;
    end else if (evt_i) begin
      m_phase = 1; m_cnt = 0;
    end else if (m_phase != 0 && tick_i) begin
      m_cnt++;
      if (m_cnt >= ((m_phase == 1) ? dly_len(cfg_i) : rate_len(cfg_i))) begin
        m_push = 1; m_phase = 2; m_cnt = 0;
      end
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model updates at the edge, outputs compared at the falling edge
  task automatic cycle(output bit pushed);
    @(posedge clk);
    if (model_on) model_step();
    @(negedge clk);
    pushed = push_o;
    if (model_on) begin
      check("R4 model push", int'(push_o), int'(m_push));
      check("R5 model code", int'(code_o), m_push ? 32'h7E : 0);
    end
  endtask

  task automatic idle_cycles(input int n, output int pushes);
    bit p;
    pushes = 0;
    for (int i = 0; i < n; i++) begin
      cycle(p);
      pushes += int'(p);
    end
  endtask

  // n ticks, each followed by a quiet cycle; counts pushes seen
  task automatic ticks(input int n, output int pushes);
    bit p;
    pushes = 0;
    for (int i = 0; i < n; i++) begin
      tick_i = 1; cycle(p); pushes += int'(p);
      tick_i = 0; cycle(p); pushes += int'(p);
    end
  endtask

  task automatic key_event();
    bit p;
    evt_i = 1; cycle(p); evt_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    bit p;
    void'($urandom(32'd1234));
    rst_n = 0; tick_i = 0; evt_i = 0; held_i = 0; cfg_i = 8'h00;
    repeat (3) @(negedge clk);
    check("R1 reset push", int'(push_o), 0);
    check("R1 reset code", int'(code_o), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    model_on = 1;

    // R3/R4: smallest delay (8) and interval (4)
    cfg_i = 8'h80; held_i = 1; key_event();
    ticks(7, n); check("R3 no push before delay d=0", n, 0);
    ticks(1, n); check("R3 push at delay d=0", n, 1);
    ticks(3, n); check("R4 no push inside interval", n, 0);
    ticks(1, n); check("R4 push at interval r=0", n, 1);
    ticks(12, n); check("R4 three more intervals", n, 3);

    // R3/R4: largest delay (128) and interval (32)
    cfg_i = 8'hFF; key_event();
    ticks(127, n); check("R3 no push before delay d=15", n, 0);
    ticks(1, n); check("R3 push at delay d=15", n, 1);
    ticks(31, n); check("R4 no push inside interval r=7", n, 0);
    ticks(1, n); check("R4 push at interval r=7", n, 1);

    // R6: release event with keys still held restarts the delay
    cfg_i = 8'h91; key_event();
    ticks(16, n); check("R6 first push d=1", n, 1);
    ticks(4, n); key_event();
    ticks(15, n); check("R6 restarted delay no push", n, 0);
    ticks(1, n); check("R6 restarted delay push", n, 1);

    // R8: event coincident with tick is not counted
    cfg_i = 8'h80; key_event();
    ticks(7, n);
    evt_i = 1; tick_i = 1; cycle(p); evt_i = 0; tick_i = 0;
    check("R8 no push on event+tick", int'(p), 0);
    ticks(7, n); check("R8 tick not counted", n, 0);
    ticks(1, n); check("R8 push after full delay", n, 1);

    // R7: dropping held clears; rising again starts nothing
    key_event(); ticks(5, n);
    held_i = 0; idle_cycles(2, n); held_i = 1;
    ticks(20, n); check("R7 no push without new event", n, 0);
    key_event(); ticks(8, n); check("R7 new event restarts", n, 1);

    // R2: disabled emits nothing
    cfg_i = 8'h00; key_event();
    ticks(40, n); check("R2 disabled no push", n, 0);

    // R9: enabling while held does not start
    cfg_i = 8'h80; ticks(20, n); check("R9 enable alone no start", n, 0);
    key_event(); ticks(8, n); check("R9 event starts", n, 1);

    // random phase
    for (int i = 0; i < 40000; i++) begin
      tick_i = ($urandom_range(0, 1) == 1);
      evt_i  = ($urandom_range(0, 59) == 0);
      if ($urandom_range(0, 299) == 0) held_i = ~held_i;
      if ($urandom_range(0, 1999) == 0)
        cfg_i = {($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)),
                 4'($urandom_range(0, 3))};
      cycle(p);
    end
    tick_i = 0; evt_i = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule